// File: doc/BRIEF.md
# Remote Terminal Built-In-Test Status Word

This block holds the 16-bit built-in-test status word of a command/response serial bus remote terminal. Hardware events set its bits: a transmitter or receiver on either of the two redundant buses being shut down, loopback and memory self-test failures, a terminal-address parity error, a failed configuration load, and the inhibiting of the terminal flag. The inputs are decoded mode-command pulses, pin levels and one-cycle self-test result pulses. A host port reads the word and can write the user field and the two loopback-failure bits.

When the terminal carries out the "transmit BIT word" mode command, the block produces the response data word one cycle later. A configuration input picks the source of that word: this register or an alternate-word input. When the register is the source, the same word goes out on a data-buffer write strobe in the following cycle. Bus encoding, the self-test engine and memory loading are outside this block.

Top module: `rt_bist_status`

## Requirements
- R1: Bit 15 (bus A) and bit 14 (bus B) read 1 in the same cycle that the matching inhibit pin is high. A mode command with code 4 or 20 for a bus (`mc_bus` 0 = A, 1 = B) latches that bus's bit from the next cycle on.
- R2: Bits 13 (bus A) and 12 (bus B) are set by a code 4 or 20 command for that bus only while `sd_rx_en` is 1. Nothing else sets them.
- R3: Bits 11..6 form a user field. A host write stores `host_wdata[11:6]` there, and the stored value reads back.
- R4: Bit 5 (bus A) and bit 4 (bus B) are set by a loopback-failure pulse and can be written by the host. When a pulse and a host write reach the same bit in one cycle, the bit ends up 1.
- R5: Bit 3 is set and held by a memory-test failure pulse. Bit 2 equals `addr_par_err` as sampled one clock earlier.
- R6: Bit 1 is set and held by a `load_fail` pulse only while `autoinit_en` is 1. A pulse while `autoinit_en` is 0 leaves it unchanged.
- R7: Bit 0 is set by a mode command with code 6 and cleared by a mode command with code 7.
- R8: Host writes leave bits 15..12 and 3..0 unchanged.
- R9: With `alt_sel` 0, a code 19 command gives `resp_valid` for one cycle in the next cycle, carrying the word as it read in the command cycle. In the cycle after that, `buf_we` is high with the same word.
- R10: With `alt_sel` 1, a code 19 command answers with `alt_word` and raises no `buf_we`.
- R11: A low `rst_n` clears every stored bit at once. A `sw_rst` pulse clears them at the next clock. After either reset, bits 15..14 show only the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous master reset, active low |
| sw_rst | input | 1 | Synchronous software reset pulse |
| inh_a | input | 1 | Bus A transmit-inhibit pin level |
| inh_b | input | 1 | Bus B transmit-inhibit pin level |
| sd_rx_en | input | 1 | Shutdown commands also disable the receiver |
| alt_sel | input | 1 | Code 19 answers with alt_word |
| alt_word | input | 16 | Alternate response word |
| autoinit_en | input | 1 | Auto-initialization enabled |
| mc_exec | input | 1 | Pulse: mode command carried out |
| mc_code | input | 5 | Mode command code |
| mc_bus | input | 1 | Bus of the command, 0 = A, 1 = B |
| lb_fail_a | input | 1 | Pulse: bus A loopback failure |
| lb_fail_b | input | 1 | Pulse: bus B loopback failure |
| mem_fail | input | 1 | Pulse: memory self-test failure |
| addr_par_err | input | 1 | Terminal address parity error level |
| load_fail | input | 1 | Pulse: configuration load failure |
| host_we | input | 1 | Host write strobe |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Current status word |
| resp_valid | output | 1 | Response data word valid |
| resp_word | output | 16 | Response data word |
| buf_we | output | 1 | Data-buffer write strobe |
| buf_wdata | output | 16 | Data-buffer write word |

## Verification
The bench fills every writable bit with a host write of all ones and checks that the read-only bits do not move. A design with a loose write mask would show the bits set by the shutdown command or the inhibit pins turning on or off. It drives a loopback-failure pulse in the same cycle as a host write of zeros, which shows whether the write wins over the hardware set. It pulses a load failure with auto-initialization off, and issues a receiver-coupled shutdown with the select bit off and then on. A scoreboard catches a BIT-word response that carries a stale word, or a buffer write that appears when the alternate word was selected.

// File: rtl/rt_bist_pkg.sv
package rt_bist_pkg;

   // Bit positions of the status word, most significant first
   localparam int TXSD_A_POS  = 15;
   localparam int TXSD_B_POS  = 14;
   localparam int RXSD_A_POS  = 13;
   localparam int RXSD_B_POS  = 12;
   localparam int USER_LO_POS = 6;
   localparam int LBF_A_POS   = 5;
   localparam int LBF_B_POS   = 4;
   localparam int MEMF_POS    = 3;
   localparam int APAR_POS    = 2;
   localparam int LOADF_POS   = 1;
   localparam int TFINH_POS   = 0;

   // Number of bits that are not part of the user field
   localparam int FIXED_BITS  = 10;

   typedef struct packed {
      logic       exec;
      logic [4:0] code;
      logic       bus_b;
   } mode_cmd_t;

endpackage

// File: rtl/rt_bist_sd_track.sv
module rt_bist_sd_track #(
   parameter int N_BUS     = 2,
   parameter int CODE_W    = 5,
   parameter int MC_SD     = 4,
   parameter int MC_SEL_SD = 20
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sw_rst,
   input  logic                 mc_exec,
   input  logic [CODE_W-1:0]    mc_code,
   input  logic                 mc_bus,
   input  logic                 sd_rx_en,
   input  logic [N_BUS-1:0]     inh,
   output logic [N_BUS-1:0]     tx_sd,
   output logic [N_BUS-1:0]     rx_sd
);

   logic sd_cmd;

   always_comb begin
      sd_cmd = mc_exec &&
               ((mc_code == CODE_W'(MC_SD)) || (mc_code == CODE_W'(MC_SEL_SD)));
   end

   for (genvar b = 0; b < N_BUS; b++) begin : g_bus
      logic hit;
      logic tx_lat;
      logic rx_lat;

      always_comb hit = sd_cmd && (int'(mc_bus) == b);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            tx_lat <= 1'b0;
            rx_lat <= 1'b0;
         end else if (sw_rst) begin
            tx_lat <= 1'b0;
            rx_lat <= 1'b0;
         end else if (hit) begin
            tx_lat <= 1'b1;
            if (sd_rx_en) rx_lat <= 1'b1;
         end
      end

      // the pin acts in the same cycle, the command latch from the next
      assign tx_sd[b] = inh[b] | tx_lat;
      assign rx_sd[b] = rx_lat;
   end

endmodule

// File: rtl/rt_bist_fault_log.sv
module rt_bist_fault_log #(
   parameter int N_BUS    = 2,
   parameter int USER_W   = 6,
   parameter int CODE_W   = 5,
   parameter int MC_INH   = 6,
   parameter int MC_OVR   = 7
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sw_rst,
   input  logic                 mc_exec,
   input  logic [CODE_W-1:0]    mc_code,
   input  logic [N_BUS-1:0]     lb_fail,
   input  logic                 mem_fail,
   input  logic                 addr_par_err,
   input  logic                 autoinit_en,
   input  logic                 load_fail,
   input  logic                 host_we,
   input  logic [USER_W-1:0]    wr_user,
   input  logic [N_BUS-1:0]     wr_lb,
   output logic [USER_W-1:0]    user_q,
   output logic [N_BUS-1:0]     lb_q,
   output logic                 mem_q,
   output logic                 par_q,
   output logic                 load_q,
   output logic                 tfi_q
);

   logic inh_cmd;
   logic ovr_cmd;

   always_comb begin
      inh_cmd = mc_exec && (mc_code == CODE_W'(MC_INH));
      ovr_cmd = mc_exec && (mc_code == CODE_W'(MC_OVR));
   end

   // user field: host read/write only
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       user_q <= '0;
      else if (sw_rst)  user_q <= '0;
      else if (host_we) user_q <= wr_user;
   end

   // loopback failures: the hardware set wins over a host write
   for (genvar b = 0; b < N_BUS; b++) begin : g_lb
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          lb_q[b] <= 1'b0;
         else if (sw_rst)     lb_q[b] <= 1'b0;
         else if (lb_fail[b]) lb_q[b] <= 1'b1;
         else if (host_we)    lb_q[b] <= wr_lb[b];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_q  <= 1'b0;
         load_q <= 1'b0;
         tfi_q  <= 1'b0;
      end else if (sw_rst) begin
         mem_q  <= 1'b0;
         load_q <= 1'b0;
         tfi_q  <= 1'b0;
      end else begin
         if (mem_fail)                 mem_q  <= 1'b1;
         if (load_fail && autoinit_en) load_q <= 1'b1;
         if (inh_cmd)                  tfi_q  <= 1'b1;
         else if (ovr_cmd)             tfi_q  <= 1'b0;
      end
   end

   // parity flag tracks the live check with one register stage
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) par_q <= 1'b0;
      else        par_q <= addr_par_err;
   end

endmodule

// File: rtl/rt_bist_resp.sv
module rt_bist_resp #(
   parameter int DATA_W   = 16,
   parameter int CODE_W   = 5,
   parameter int MC_TXBIT = 19
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 mc_exec,
   input  logic [CODE_W-1:0]    mc_code,
   input  logic                 alt_sel,
   input  logic [DATA_W-1:0]    alt_word,
   input  logic [DATA_W-1:0]    cur_word,
   output logic                 resp_valid,
   output logic [DATA_W-1:0]    resp_word,
   output logic                 buf_we,
   output logic [DATA_W-1:0]    buf_wdata
);

   logic bit_cmd;
   logic buf_pend;

   always_comb bit_cmd = mc_exec && (mc_code == CODE_W'(MC_TXBIT));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         resp_valid <= 1'b0;
         resp_word  <= '0;
         buf_pend   <= 1'b0;
      end else begin
         resp_valid <= bit_cmd;
         buf_pend   <= bit_cmd && !alt_sel;
         if (bit_cmd) resp_word <= alt_sel ? alt_word : cur_word;
      end
   end

   // buffer copy after the response has gone out
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_we    <= 1'b0;
         buf_wdata <= '0;
      end else begin
         buf_we <= resp_valid && buf_pend;
         if (resp_valid && buf_pend) buf_wdata <= resp_word;
      end
   end

endmodule

// File: rtl/rt_bist_status.sv
module rt_bist_status
   import rt_bist_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int USER_W    = 6,
   parameter int N_BUS     = 2,
   parameter int CODE_W    = 5,
   parameter int MC_SD     = 4,
   parameter int MC_SEL_SD = 20,
   parameter int MC_INH    = 6,
   parameter int MC_OVR    = 7,
   parameter int MC_TXBIT  = 19
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_rst,
   input  logic              inh_a,
   input  logic              inh_b,
   input  logic              sd_rx_en,
   input  logic              alt_sel,
   input  logic [DATA_W-1:0] alt_word,
   input  logic              autoinit_en,
   input  logic              mc_exec,
   input  logic [CODE_W-1:0] mc_code,
   input  logic              mc_bus,
   input  logic              lb_fail_a,
   input  logic              lb_fail_b,
   input  logic              mem_fail,
   input  logic              addr_par_err,
   input  logic              load_fail,
   input  logic              host_we,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   output logic              resp_valid,
   output logic [DATA_W-1:0] resp_word,
   output logic              buf_we,
   output logic [DATA_W-1:0] buf_wdata
);

   localparam int USER_HI = USER_LO_POS + USER_W - 1;

   if (DATA_W != USER_W + FIXED_BITS) begin : g_bad_width
      initial $fatal(1, "DATA_W must equal USER_W + %0d", FIXED_BITS);
   end
   if (N_BUS != 2) begin : g_bad_bus
      initial $fatal(1, "N_BUS must be 2");
   end
   if (CODE_W < 5) begin : g_bad_code
      initial $fatal(1, "CODE_W must hold code values up to 31");
   end

   logic [N_BUS-1:0]  inh_v, tx_sd, rx_sd, lb_v, lb_q, wr_lb;
   logic [USER_W-1:0] user_q;
   logic              mem_q, par_q, load_q, tfi_q;

   assign inh_v = {inh_b, inh_a};
   assign lb_v  = {lb_fail_b, lb_fail_a};
   assign wr_lb = {host_wdata[LBF_B_POS], host_wdata[LBF_A_POS]};

   rt_bist_sd_track #(
      .N_BUS(N_BUS), .CODE_W(CODE_W), .MC_SD(MC_SD), .MC_SEL_SD(MC_SEL_SD)
   ) u_sd (
      .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst),
      .mc_exec(mc_exec), .mc_code(mc_code), .mc_bus(mc_bus),
      .sd_rx_en(sd_rx_en), .inh(inh_v), .tx_sd(tx_sd), .rx_sd(rx_sd)
   );

   rt_bist_fault_log #(
      .N_BUS(N_BUS), .USER_W(USER_W), .CODE_W(CODE_W),
      .MC_INH(MC_INH), .MC_OVR(MC_OVR)
   ) u_log (
      .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst),
      .mc_exec(mc_exec), .mc_code(mc_code), .lb_fail(lb_v),
      .mem_fail(mem_fail), .addr_par_err(addr_par_err),
      .autoinit_en(autoinit_en), .load_fail(load_fail),
      .host_we(host_we), .wr_user(host_wdata[USER_HI:USER_LO_POS]),
      .wr_lb(wr_lb), .user_q(user_q), .lb_q(lb_q), .mem_q(mem_q),
      .par_q(par_q), .load_q(load_q), .tfi_q(tfi_q)
   );

   always_comb begin
      host_rdata              = '0;
      host_rdata[TXSD_A_POS]  = tx_sd[0];
      host_rdata[TXSD_B_POS]  = tx_sd[1];
      host_rdata[RXSD_A_POS]  = rx_sd[0];
      host_rdata[RXSD_B_POS]  = rx_sd[1];
      host_rdata[USER_HI:USER_LO_POS] = user_q;
      host_rdata[LBF_A_POS]   = lb_q[0];
      host_rdata[LBF_B_POS]   = lb_q[1];
      host_rdata[MEMF_POS]    = mem_q;
      host_rdata[APAR_POS]    = par_q;
      host_rdata[LOADF_POS]   = load_q;
      host_rdata[TFINH_POS]   = tfi_q;
   end

   rt_bist_resp #(
      .DATA_W(DATA_W), .CODE_W(CODE_W), .MC_TXBIT(MC_TXBIT)
   ) u_resp (
      .clk(clk), .rst_n(rst_n), .mc_exec(mc_exec), .mc_code(mc_code),
      .alt_sel(alt_sel), .alt_word(alt_word), .cur_word(host_rdata),
      .resp_valid(resp_valid), .resp_word(resp_word),
      .buf_we(buf_we), .buf_wdata(buf_wdata)
   );

endmodule

// File: rtl/rt_bist_chk.sv
module rt_bist_chk #(
   parameter int DATA_W = 16,
   parameter int CODE_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sw_rst,
   input logic              inh_a,
   input logic              inh_b,
   input logic              mc_exec,
   input logic [CODE_W-1:0] mc_code,
   input logic              addr_par_err,
   input logic              load_fail,
   input logic              autoinit_en,
   input logic [DATA_W-1:0] host_rdata,
   input logic              resp_valid,
   input logic [DATA_W-1:0] resp_word,
   input logic              buf_we,
   input logic [DATA_W-1:0] buf_wdata
);

   AST_TX_PIN_A: assert property (@(posedge clk) disable iff (!rst_n)
      inh_a |-> host_rdata[15]);                                   // R1
   AST_TX_PIN_B: assert property (@(posedge clk) disable iff (!rst_n)
      inh_b |-> host_rdata[14]);                                   // R1
   AST_RX_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(host_rdata[13]) |-> $past(mc_exec));                   // R2
   AST_PAR_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
      addr_par_err |=> host_rdata[2]);                             // R5
   AST_LOAD_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(host_rdata[1]) |-> $past(load_fail && autoinit_en));   // R6
   AST_TFI_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (mc_exec && mc_code == CODE_W'(6) && !sw_rst) |=> host_rdata[0]);   // R7
   AST_TFI_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (mc_exec && mc_code == CODE_W'(7)) |=> !host_rdata[0]);      // R7
   AST_RESP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid && !$past(mc_exec) |-> 1'b0);                     // R9
   AST_BUF_AFTER_RESP: assert property (@(posedge clk) disable iff (!rst_n)
      buf_we |-> $past(resp_valid) && buf_wdata == $past(resp_word));     // R9
   AST_SW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_rst && !mc_exec) |=> host_rdata[0] == 1'b0);             // R11

endmodule

bind rt_bist_status rt_bist_chk #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_chk (.*);

// File: tb/sim_rt_bist_status.sv
module sim_rt_bist_status;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sw_rst = 0, inh_a = 0, inh_b = 0, sd_rx_en = 0, alt_sel = 0;
   logic [15:0] alt_word = '0;
   logic        autoinit_en = 0, mc_exec = 0, mc_bus = 0;
   logic [4:0]  mc_code = '0;
   logic        lb_fail_a = 0, lb_fail_b = 0, mem_fail = 0, addr_par_err = 0, load_fail = 0;
   logic        host_we = 0;
   logic [15:0] host_wdata = '0;
   logic [15:0] host_rdata, resp_word, buf_wdata;
   logic        resp_valid, buf_we;

   typedef struct { bit is_buf; logic [15:0] word; string tag; } exp_t;
   exp_t sb_q[$];

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rt_bist_status u0 (.*);

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // monitor: pops the scoreboard as responses and buffer writes appear
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (resp_valid) begin
            if (sb_q.size() == 0 || sb_q[0].is_buf) begin
               check("R10 unexpected response", resp_word, 16'hxxxx);
            end else begin
               check(sb_q[0].tag, resp_word, sb_q[0].word);
               void'(sb_q.pop_front());
            end
         end
         if (buf_we) begin
            if (sb_q.size() == 0 || !sb_q[0].is_buf) begin
               check("R10 unexpected buffer write", buf_wdata, 16'hxxxx);
            end else begin
               check(sb_q[0].tag, buf_wdata, sb_q[0].word);
               void'(sb_q.pop_front());
            end
         end
      end
   end

   task automatic mode_cmd(input logic [4:0] code, input logic bus);
      @(negedge clk);
      mc_exec = 1; mc_code = code; mc_bus = bus;
      @(negedge clk);
      mc_exec = 0;
   endtask

   task automatic host_write(input logic [15:0] d);
      @(negedge clk);
      host_we = 1; host_wdata = d;
      @(negedge clk);
      host_we = 0;
   endtask

   task automatic bit_word_cmd(input logic alt, input logic [15:0] exp_word);
      alt_sel = alt;
      sb_q.push_back('{0, exp_word, alt ? "R10 alternate response" : "R9 response word"});
      if (!alt) sb_q.push_back('{1, exp_word, "R9 buffer copy"});
      mode_cmd(5'd19, 1'b0);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (CLK_PERIOD * 20000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R11 reset value", host_rdata, 16'h0000);
      rst_n = 1;
      @(negedge clk);

      // R1 pin acts at once and leaves nothing behind
      inh_a = 1; #1;
      check("R1 pin A", host_rdata, 16'h8000);
      @(negedge clk); inh_a = 0; #1;
      check("R1 pin A released", host_rdata, 16'h0000);

      // R1 R2 command on bus B without receiver coupling
      mode_cmd(5'd4, 1'b1);
      check("R2 code 4 bus B, no rx", host_rdata, 16'h4000);
      sd_rx_en = 1;
      mode_cmd(5'd20, 1'b0);
      check("R2 code 20 bus A with rx", host_rdata, 16'hE000);

      // R3 R4 R8 all-ones write
      host_write(16'hFFFF);
      check("R8 R3 all-ones write", host_rdata, 16'hEFF0);

      // R4 hardware set beats same-cycle write of zero
      @(negedge clk);
      host_we = 1; host_wdata = 16'h0000; lb_fail_a = 1;
      @(negedge clk);
      host_we = 0; lb_fail_a = 0;
      check("R4 set wins over write", host_rdata, 16'hE020);
      mode_cmd(5'd0, 1'b0);
      @(negedge clk); lb_fail_b = 1; @(negedge clk); lb_fail_b = 0;
      check("R4 bus B loopback", host_rdata, 16'hE030);

      // R5 memory failure is held, host write cannot clear it
      @(negedge clk); mem_fail = 1; @(negedge clk); mem_fail = 0;
      host_write(16'h0000);
      check("R5 R8 memory flag held", host_rdata, 16'hE008);

      // R5 parity tracks input
      @(negedge clk); addr_par_err = 1; @(negedge clk);
      check("R5 parity set", host_rdata, 16'hE00C);
      addr_par_err = 0; @(negedge clk);
      check("R5 parity follows", host_rdata, 16'hE008);

      // R6 load failure gated by auto-init enable
      @(negedge clk); load_fail = 1; @(negedge clk); load_fail = 0;
      check("R6 ignored when disabled", host_rdata, 16'hE008);
      autoinit_en = 1;
      @(negedge clk); load_fail = 1; @(negedge clk); load_fail = 0;
      check("R6 set when enabled", host_rdata, 16'hE00A);

      // R7 terminal flag inhibit and override
      mode_cmd(5'd6, 1'b0);
      check("R7 inhibit", host_rdata, 16'hE00B);
      mode_cmd(5'd7, 1'b0);
      check("R7 override", host_rdata, 16'hE00A);

      // R9 R10 BIT-word command
      bit_word_cmd(1'b0, 16'hE00A);
      alt_word = 16'h1234;
      bit_word_cmd(1'b1, 16'h1234);
      mode_cmd(5'd6, 1'b1);
      bit_word_cmd(1'b0, 16'hE00B);

      // R11 software reset, then master reset
      host_write(16'h0A40);
      @(negedge clk); sw_rst = 1; @(negedge clk); sw_rst = 0;
      check("R11 software reset", host_rdata, 16'h0000);
      inh_b = 1; #1;
      check("R11 pin after reset", host_rdata, 16'h4000);
      inh_b = 0;
      host_write(16'h0FC0);
      mode_cmd(5'd6, 1'b0);
      #2 rst_n = 0; #1;
      check("R11 master reset", host_rdata, 16'h0000);
      @(negedge clk); rst_n = 1;
      @(negedge clk);

      done = 1;
      check("R9 scoreboard drained", 16'(sb_q.size()), 16'h0000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule